// File: doc/BRIEF.md
# MDIO Management Controller

This block is a register-driven station-management master. Software fills a 16-bit data register and then writes a control word. The control word holds a PHY address, a register number, a write flag, a start/busy flag and a 4-bit clock-divider code. The controller then sends one clause-22 frame on the serial management pair. It generates MDC from the system clock and drives MDIO through an output enable. For a read, it releases the line at the turnaround and shifts the PHY's reply into the data register.

Software polls the busy flag. The busy flag stays at 1 from the accepted start write until the last bit has been clocked out, and then the hardware clears it. A separate enable input gates MDC. While that input is low, MDC holds its level and the frame pauses without losing its place. Control or data writes that arrive during a frame are dropped.

Top module: `mdio_mgmt`

## Requirements
- R1: After reset, both register read ports return 0, MDC is low and the MDIO output enable is low.
- R2: The control readback places the register number in bits 4:0, the PHY address in 12:8, the write flag in 16, busy in 17 and the divider code in 23:20. All other readback bits are 0, and the data readback has its upper 16 bits at 0.
- R3: A control write with bit 17 set while idle starts a frame, and busy reads 1 from the next cycle until the frame ends. A control write with bit 17 clear only stores the fields and starts nothing.
- R4: A frame is 64 MDC periods sent MSB first. It consists of 32 ones, start 01, opcode 01 for write or 10 for read, the PHY address, the register number, turnaround 10 (write only), and 16 data bits.
- R5: Divider codes 0 to 15 give MDC periods of 4, 6, 8, 12, 16, 20, 24, 28, 30, 32, 36, 40, 44, 48, 54 and 60 system clocks, with equal high and low halves.
- R6: MDIO output changes only while MDC is low, so it is steady across every MDC high phase.
- R7: In a read, the output enable is low from the first turnaround bit (bit 46) onward. The input is sampled at each MDC rising edge of bits 48 to 63. When busy clears, the data readback holds the sampled 16 bits, first bit in bit 15.
- R8: In a write, the output enable is high for all 64 bits and the data register's low 16 bits are sent.
- R9: While the MDC enable input is low, MDC does not change and a running frame stays busy. The frame resumes and completes once the enable returns.
- R10: Control and data writes that arrive while busy is 1 are ignored and have no effect on the stored fields or on the frame in flight.
- R11: While idle, MDC is low and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control register write value |
| ctl_rdata | output | 32 | Control register readback |
| data_we | input | 1 | Data register write strobe |
| data_wdata | input | 32 | Data register write value (low 16 bits used) |
| data_rdata | output | 32 | Data register readback |
| mdc_en | input | 1 | MDC enable; low freezes MDC and the frame |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Serial data output enable |
| mdio_i | input | 1 | Serial data in |

## Verification
Embedded properties guard the following on every cycle:
- the idle levels of MDC and the output enable;
- the steadiness of the data line across MDC high phases;
- the freeze of MDC while its enable is low;
- the release of the line during a read's turnaround and data bits;
- the immunity of the stored fields to writes made while busy.

Only the bench's scenarios can show the following, because they need whole-frame knowledge:
- the bit-exact frame contents for both opcodes;
- the MDC period for each divider code;
- the returned read data;
- the completion of a frame that was paused partway.

// File: rtl/mdio_mgmt.sv
module mdio_mgmt (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_we,
  input  logic [31:0] ctl_wdata,
  output logic [31:0] ctl_rdata,
  input  logic        data_we,
  input  logic [31:0] data_wdata,
  output logic [31:0] data_rdata,
  input  logic        mdc_en,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  localparam logic [5:0] LAST_BIT  = 6'd63;
  localparam logic [5:0] TA_BIT    = 6'd46;
  localparam logic [5:0] DATA_BIT  = 6'd48;

  logic        busy, wr_q, mdc_q, oe_q;
  logic [4:0]  reg_q, phy_q, cnt;
  logic [3:0]  div_q;
  logic [15:0] data_q;
  logic [63:0] sh;
  logic [5:0]  idx;
  logic        start, tick;

  function automatic logic [4:0] half_m1(input logic [3:0] code);
    logic [5:0] r;
    case (code)
      4'h0: r = 6'd4;   4'h1: r = 6'd6;   4'h2: r = 6'd8;   4'h3: r = 6'd12;
      4'h4: r = 6'd16;  4'h5: r = 6'd20;  4'h6: r = 6'd24;  4'h7: r = 6'd28;
      4'h8: r = 6'd30;  4'h9: r = 6'd32;  4'hA: r = 6'd36;  4'hB: r = 6'd40;
      4'hC: r = 6'd44;  4'hD: r = 6'd48;  4'hE: r = 6'd54;  default: r = 6'd60;
    endcase
    return r[5:1] - 5'd1;
  endfunction

  assign start = ctl_we && ctl_wdata[17] && !busy;
  assign tick  = busy && mdc_en && (cnt == 5'd0);

  assign ctl_rdata  = {8'h00, div_q, 2'b00, busy, wr_q, 3'b000, phy_q, 3'b000, reg_q};
  assign data_rdata = {16'h0000, data_q};
  assign mdc        = mdc_q;
  assign mdio_o     = sh[63];
  assign mdio_oe    = oe_q;

  logic unused_wbits;
  assign unused_wbits = ^{ctl_wdata[31:24], ctl_wdata[19:18], ctl_wdata[15:13],
                          ctl_wdata[7:5], data_wdata[31:16]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; wr_q <= 1'b0; mdc_q <= 1'b0; oe_q <= 1'b0;
      reg_q <= '0; phy_q <= '0; div_q <= '0; data_q <= '0;
      cnt <= '0; idx <= '0; sh <= '0;
    end else begin
      if (ctl_we && !busy) begin
        reg_q <= ctl_wdata[4:0];
        phy_q <= ctl_wdata[12:8];
        wr_q  <= ctl_wdata[16];
        div_q <= ctl_wdata[23:20];
      end
      if (data_we && !busy)
        data_q <= data_wdata[15:0];
      if (start) begin
        busy  <= 1'b1;
        idx   <= '0;
        mdc_q <= 1'b0;
        oe_q  <= 1'b1;
        cnt   <= half_m1(ctl_wdata[23:20]);
        sh    <= {32'hFFFF_FFFF, 2'b01,
                  ctl_wdata[16] ? 2'b01 : 2'b10,
                  ctl_wdata[12:8], ctl_wdata[4:0],
                  ctl_wdata[16] ? 2'b10 : 2'b11,
                  ctl_wdata[16] ? data_q : 16'hFFFF};
      end else if (busy && mdc_en) begin
        if (!tick) begin
          cnt <= cnt - 5'd1;
        end else begin
          cnt <= half_m1(div_q);
          if (!mdc_q) begin
            mdc_q <= 1'b1;
            if (!wr_q && idx >= DATA_BIT)
              data_q <= {data_q[14:0], mdio_i};
          end else begin
            mdc_q <= 1'b0;
            if (idx == LAST_BIT) begin
              busy <= 1'b0;
              oe_q <= 1'b0;
              idx  <= '0;
            end else begin
              idx <= idx + 6'd1;
              sh  <= {sh[62:0], 1'b1};
              if (!wr_q && idx == TA_BIT - 6'd1)
                oe_q <= 1'b0;
            end
          end
        end
      end
    end
  end

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  a_r6_out_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> $stable(mdio_o));

  a_r9_mdc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!mdc_en && busy) |=> $stable(mdc));

  a_r7_read_released: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wr_q && idx >= TA_BIT) |-> !mdio_oe);

  a_r10_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (ctl_we || data_we)) |=> ($stable({ctl_rdata[31:18], ctl_rdata[16:0]}) &&
                                       (wr_q ? $stable(data_rdata) : 1'b1)));

  a_r3_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[17] && !ctl_rdata[17]) |=> ctl_rdata[17]);

endmodule

// File: tb/mdio_mgmt_test.sv
module mdio_mgmt_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 1'b0, data_we = 1'b0, mdc_en = 1'b1, mdio_i = 1'b1;
  logic [31:0] ctl_wdata = '0, data_wdata = '0;
  logic [31:0] ctl_rdata, data_rdata;
  logic mdc, mdio_o, mdio_oe;

  mdio_mgmt uut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .data_we(data_we), .data_wdata(data_wdata),
    .data_rdata(data_rdata), .mdc_en(mdc_en), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [63:0] exp_q[$];
  bit          rd_q[$];
  int          k = 0, per_bad = 0, oe_bad = 0, exp_ratio = 4;
  bit          chk_period = 1'b1;
  logic [63:0] cap = '0;
  logic [15:0] rd_val = '0;
  time         last_rise = 0;

  function automatic int ratio_of(input int code);
    int tbl[16] = '{4, 6, 8, 12, 16, 20, 24, 28, 30, 32, 36, 40, 44, 48, 54, 60};
    return tbl[code];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  always @(posedge mdc) begin
    bit is_rd;
    is_rd = (rd_q.size() > 0) ? rd_q[0] : 1'b0;
    if (k > 0 && chk_period && (($time - last_rise) != time'(exp_ratio * CLK_PERIOD)))
      per_bad++;
    last_rise = $time;
    if (is_rd && k >= 46) begin
      if (mdio_oe) oe_bad++;
    end else if (!mdio_oe) oe_bad++;
    cap = {cap[62:0], mdio_o};
    if (is_rd && k >= 47 && k <= 62) mdio_i = rd_val[62-k];
    else mdio_i = 1'b1;
    k++;
    if (k == 64) begin
      logic [63:0] e;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 64'h0;
      if (rd_q.size() > 0) void'(rd_q.pop_front());
      if (is_rd)
        chk(cap[63:18] == e[63:18], "R4", "read frame header", {18'h0, cap[63:18]}, {18'h0, e[63:18]});
      else
        chk(cap == e, "R4", "write frame bits", cap, e);
      chk(oe_bad == 0, is_rd ? "R7" : "R8", "output enable pattern", oe_bad, 0);
      if (chk_period)
        chk(per_bad == 0, "R5", $sformatf("MDC period ratio %0d", exp_ratio), per_bad, 0);
      k = 0; per_bad = 0; oe_bad = 0;
    end
  end

  task automatic wr_ctl(input logic [31:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr_data(input logic [31:0] v);
    @(negedge clk); data_we = 1'b1; data_wdata = v;
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic launch(input bit rd, input logic [3:0] code, input logic [4:0] phy,
                        input logic [4:0] rg, input logic [15:0] val, input bit per_on);
    if (!rd) wr_data({16'hBEEF, val});
    exp_q.push_back({32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, rg, 2'b10, val});
    rd_q.push_back(rd);
    rd_val = val; exp_ratio = ratio_of(int'(code)); chk_period = per_on; k = 0;
    wr_ctl({8'h00, code, 2'b00, 1'b1, ~rd, 3'b000, phy, 3'b000, rg});
    chk(ctl_rdata[17] == 1'b1, "R3", "busy after start", ctl_rdata[17], 1);
  endtask

  task automatic finish_frame(input bit rd, input logic [15:0] val);
    int n = 0;
    while (ctl_rdata[17] && n < 6000) begin @(negedge clk); n++; end
    chk(ctl_rdata[17] == 1'b0, "R3", "busy cleared at end", ctl_rdata[17], 0);
    chk(exp_q.size() == 0, "R4", "frame observed", exp_q.size(), 0);
    if (rd) chk(data_rdata == {16'h0, val}, "R7", "read data", data_rdata, {16'h0, val});
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctl_rdata == 0, "R1", "control reset", ctl_rdata, 0);
    chk(data_rdata == 0, "R1", "data reset", data_rdata, 0);
    chk(!mdc && !mdio_oe, "R1", "mdc/oe reset", {mdc, mdio_oe}, 0);

    wr_ctl(32'h803D_150A);
    chk(ctl_rdata == 32'h0031_150A, "R2", "field readback", ctl_rdata, 32'h0031_150A);
    begin
      int moves = 0;
      repeat (40) begin @(negedge clk); if (mdc || mdio_oe || ctl_rdata[17]) moves++; end
      chk(moves == 0, "R3", "no frame without start bit", moves, 0);
    end
    wr_data(32'hDEAD_A5C3);
    chk(data_rdata == 32'h0000_A5C3, "R2", "data readback", data_rdata, 32'h0000_A5C3);

    launch(1'b0, 4'h0, 5'd5, 5'd3, 16'hA5C3, 1'b1);
    finish_frame(1'b0, 16'hA5C3);

    launch(1'b1, 4'h9, 5'd31, 5'd17, 16'h9E2B, 1'b1);
    finish_frame(1'b1, 16'h9E2B);

    launch(1'b0, 4'hF, 5'd12, 5'd30, 16'h1234, 1'b1);
    repeat (300) @(negedge clk);
    wr_ctl(32'h0026_0705);
    wr_data(32'h0000_FFFF);
    finish_frame(1'b0, 16'h1234);
    chk(ctl_rdata == 32'h00F1_0C1E, "R10", "fields after busy write", ctl_rdata, 32'h00F1_0C1E);
    chk(data_rdata == 32'h0000_1234, "R10", "data after busy write", data_rdata, 32'h0000_1234);

    launch(1'b1, 4'h2, 5'd1, 5'd2, 16'h4C71, 1'b0);
    repeat (100) @(negedge clk);
    mdc_en = 1'b0;
    begin
      logic m; int moves = 0;
      @(negedge clk); m = mdc;
      repeat (200) begin @(negedge clk); if (mdc !== m) moves++; end
      chk(moves == 0, "R9", "mdc frozen", moves, 0);
      chk(ctl_rdata[17] == 1'b1, "R9", "busy while frozen", ctl_rdata[17], 1);
    end
    mdc_en = 1'b1;
    finish_frame(1'b1, 16'h4C71);

    foreach (rd_val[i]) begin end
    for (int c = 0; c < 16; c += 5) begin
      launch(c[0], 4'(c + 1), 5'(c + 2), 5'(31 - c), 16'(16'h3C5A ^ c), 1'b1);
      finish_frame(c[0], 16'(16'h3C5A ^ c));
    end

    chk(!mdc && !mdio_oe, "R11", "idle after frames", {mdc, mdio_oe}, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule